// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multiple-register load or store instruction into a series of single-word memory beats. At a start strobe it reads the 16-bit register list from the instruction word. It then presents one beat per selected register, lowest register first. Each beat carries the register index, the byte address, a load/store flag and, when the program counter is being stored, the value to be written in its place. After the last beat it reports the base-register writeback value.

The instruction's mode bits pick the address plan. Counting up or down, combined with adjusting before or after the access, gives four placements of the block of words relative to the base. The downstream consumer paces the walk with a ready input, and one beat completes per clock while ready is high. Instructions that request privileged user-bank transfer are refused with a one-cycle error pulse. An empty list finishes at once.

Top module: `blk_xfer_seq`

## Requirements
- R1: The register list is insn[15:0]. One beat is issued per set bit, in ascending register index, so the beat count equals the population count of the list.
- R2: With insn[23]=1 (count up), the first beat address is base+4 when insn[24]=1 and base when insn[24]=0.
- R3: With insn[23]=0 (count down) and n beats, the first beat address is base-4n when insn[24]=1 and base-4(n-1) when insn[24]=0.
- R4: Each beat after the first has the address of the previous beat plus 4.
- R5: In the done cycle, wb_en_o equals insn[21]. wb_val_o is base+4n for count-up and base-4n for count-down. wb_en_o is never high outside a done cycle.
- R6: beat_pcval_o equals the instruction address plus 12. beat_pcsub_o is high exactly on a store beat for register 15.
- R7: beat_load_o equals insn[20] (1 = load, 0 = store) on every beat.
- R8: An accepted start with insn[22]=1 raises err_o for exactly one cycle, the cycle after the start. It produces no beat, no done and no writeback.
- R9: While beat_valid_o is high and ready_i is low, the beat holds with the same register and address.
- R10: An accepted start with an empty list produces no beat. It raises done_o in the next cycle, with wb_en_o=insn[21] and wb_val_o=base.
- R11: A start while beat_valid_o is high is ignored. The current beat and all later beats are unchanged, and no err_o or done_o results.
- R12: The first beat appears in the cycle after the accepted start. done_o pulses for one cycle in the cycle after the last beat is accepted, with beat_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when no beat is pending |
| insn_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| iaddr_i | input | 32 | Address of the instruction |
| ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_addr_o | output | 32 | Byte address of the beat |
| beat_load_o | output | 1 | 1 = load, 0 = store |
| beat_pcsub_o | output | 1 | Store data must be replaced by beat_pcval_o |
| beat_pcval_o | output | 32 | Substitute value for a stored program counter |
| done_o | output | 1 | Sequence complete, one-cycle pulse |
| wb_en_o | output | 1 | Write wb_val_o to the base register |
| wb_val_o | output | 32 | Base writeback value |
| err_o | output | 1 | Illegal instruction pulse |

## Verification
The hardest case to reach from the ports is a second start that arrives while a beat is still pending. The stimulus drops ready for one cycle on the first beat of a sequence. In that same cycle it pulses start with an illegal instruction word. The bench then confirms that the beat, all later beats and the final writeback match the original instruction, and that no error pulse appears. Stalls are also interleaved on alternate cycles within a sequence, so that address stepping is checked across held beats.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  // instruction field positions that the decode depends on
  localparam int BIT_PRE   = 24;
  localparam int BIT_UP    = 23;
  localparam int BIT_PRIV  = 22;
  localparam int BIT_WBACK = 21;
  localparam int BIT_LOAD  = 20;

  typedef struct packed {
    logic pre;
    logic up;
    logic priv;
    logic wback;
    logic load;
  } bxs_ctl_t;

  function automatic bxs_ctl_t bxs_ctl(input logic [31:0] w);
    bxs_ctl_t c;
    c.pre   = w[BIT_PRE];
    c.up    = w[BIT_UP];
    c.priv  = w[BIT_PRIV];
    c.wback = w[BIT_WBACK];
    c.load  = w[BIT_LOAD];
    return c;
  endfunction
endpackage

// File: rtl/bxs_popcount.sv
module bxs_popcount #(
  parameter int NREG = 16,
  parameter int CW   = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [CW-1:0]   count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NREG; i++) begin
      count_o = count_o + CW'(mask_i[i]);
    end
  end
endmodule

// File: rtl/bxs_lowest.sv
module bxs_lowest #(
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IDXW-1:0] idx_o,
  output logic [NREG-1:0] rest_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDXW'(i);
    end
    rest_o = mask_i & (mask_i - NREG'(1));
  end
endmodule

// File: rtl/bxs_addr_plan.sv
module bxs_addr_plan #(
  parameter int DW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [DW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          up_i,
  input  logic          pre_i,
  output logic [DW-1:0] first_o,
  output logic [DW-1:0] wb_o
);
  logic [DW-1:0] span;

  always_comb begin
    span = DW'(count_i) * DW'(STEP);
    if (up_i) begin
      first_o = pre_i ? base_i + DW'(STEP) : base_i;
      wb_o    = base_i + span;
    end else begin
      first_o = pre_i ? base_i - span : base_i - span + DW'(STEP);
      wb_o    = base_i - span;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int DW        = 32,
  parameter int NREG      = 16,
  parameter int STEP      = 4,
  parameter int PC_AHEAD  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [31:0]   insn_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] iaddr_i,
  input  logic          ready_i,
  output logic          beat_valid_o,
  output logic [3:0]    beat_reg_o,
  output logic [DW-1:0] beat_addr_o,
  output logic          beat_load_o,
  output logic          beat_pcsub_o,
  output logic [DW-1:0] beat_pcval_o,
  output logic          done_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_val_o,
  output logic          err_o
);
  import bxs_pkg::*;

  localparam int IDXW = $clog2(NREG);
  localparam int CW   = $clog2(NREG + 1);
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

  bxs_ctl_t        ctl;
  logic [NREG-1:0] list;
  logic [CW-1:0]   n_xfer;
  logic [IDXW-1:0] first_idx, next_idx;
  logic [NREG-1:0] first_rest, next_rest;
  logic [DW-1:0]   first_addr, wb_calc;

  logic            valid_q, load_q, wbflag_q, done_q, err_q, wb_en_q;
  logic [IDXW-1:0] reg_q;
  logic [NREG-1:0] mask_q;
  logic [DW-1:0]   addr_q, pcval_q, wbhold_q, wb_val_q;
  logic            start_ok, fire;

  assign ctl      = bxs_ctl(insn_i);
  assign list     = insn_i[NREG-1:0];
  assign start_ok = start_i && !valid_q;
  assign fire     = valid_q && ready_i;

  bxs_popcount #(.NREG(NREG), .CW(CW)) u_cnt (
    .mask_i (list),
    .count_o(n_xfer)
  );

  bxs_lowest #(.NREG(NREG), .IDXW(IDXW)) u_first (
    .mask_i(list),
    .idx_o (first_idx),
    .rest_o(first_rest)
  );

  bxs_lowest #(.NREG(NREG), .IDXW(IDXW)) u_next (
    .mask_i(mask_q),
    .idx_o (next_idx),
    .rest_o(next_rest)
  );

  bxs_addr_plan #(.DW(DW), .CW(CW), .STEP(STEP)) u_plan (
    .base_i (base_i),
    .count_i(n_xfer),
    .up_i   (ctl.up),
    .pre_i  (ctl.pre),
    .first_o(first_addr),
    .wb_o   (wb_calc)
  );

  // mask_q holds the registers still to come after the current beat
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      load_q   <= 1'b0;
      wbflag_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      wb_en_q  <= 1'b0;
      reg_q    <= '0;
      mask_q   <= '0;
      addr_q   <= '0;
      pcval_q  <= '0;
      wbhold_q <= '0;
      wb_val_q <= '0;
    end else begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wb_en_q <= 1'b0;
      if (start_ok) begin
        if (ctl.priv) begin
          err_q <= 1'b1;
        end else if (list == '0) begin
          done_q   <= 1'b1;
          wb_en_q  <= ctl.wback;
          wb_val_q <= wb_calc;
        end else begin
          valid_q  <= 1'b1;
          reg_q    <= first_idx;
          mask_q   <= first_rest;
          addr_q   <= first_addr;
          load_q   <= ctl.load;
          pcval_q  <= iaddr_i + DW'(PC_AHEAD);
          wbhold_q <= wb_calc;
          wbflag_q <= ctl.wback;
        end
      end else if (fire) begin
        addr_q <= addr_q + DW'(STEP);
        if (mask_q == '0) begin
          valid_q  <= 1'b0;
          done_q   <= 1'b1;
          wb_en_q  <= wbflag_q;
          wb_val_q <= wbhold_q;
        end else begin
          reg_q  <= next_idx;
          mask_q <= next_rest;
        end
      end
    end
  end

  assign beat_valid_o = valid_q;
  assign beat_reg_o   = 4'(reg_q);
  assign beat_addr_o  = addr_q;
  assign beat_load_o  = load_q;
  assign beat_pcsub_o = valid_q && !load_q && (reg_q == PC_IDX);
  assign beat_pcval_o = pcval_q;
  assign done_o       = done_q;
  assign wb_en_o      = wb_en_q;
  assign wb_val_o     = wb_val_q;
  assign err_o        = err_q;

  // R4: consecutive beats step by one word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ready_i) |=> (!valid_q || addr_q == $past(addr_q) + DW'(STEP)));

  // R1: register indices strictly rise within a sequence
  p_reg_ascend_r1: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ready_i) |=> (!valid_q || reg_q > $past(reg_q)));

  // R9: a stalled beat holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(reg_q) && $stable(addr_q)));

  // R8: an error pulse carries no other activity
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!valid_q && !done_q && !wb_en_q));

  // R5: writeback only in a done cycle
  p_wb_in_done_r5: assert property (@(posedge clk) disable iff (rst)
    wb_en_q |-> done_q);

  // R12: done is never shown alongside a beat
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !valid_q);

  // R11: a start during a pending beat causes no pulse
  p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i && start_i) |=> (!err_q && !done_q));
endmodule

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i = 1'b0;
  logic [31:0] insn_i = '0, base_i = '0, iaddr_i = '0;
  logic        ready_i = 1'b1;
  logic        beat_valid_o, beat_load_o, beat_pcsub_o, done_o, wb_en_o, err_o;
  logic [3:0]  beat_reg_o;
  logic [31:0] beat_addr_o, beat_pcval_o, wb_val_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .insn_i(insn_i),
    .base_i(base_i), .iaddr_i(iaddr_i), .ready_i(ready_i),
    .beat_valid_o(beat_valid_o), .beat_reg_o(beat_reg_o),
    .beat_addr_o(beat_addr_o), .beat_load_o(beat_load_o),
    .beat_pcsub_o(beat_pcsub_o), .beat_pcval_o(beat_pcval_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit pre, input bit up, input bit priv,
                                     input bit wb, input bit ld, input logic [15:0] lst);
    return {4'hE, 3'b100, pre, up, priv, wb, ld, 4'h1, lst};
  endfunction

  // drives one instruction and checks every beat and the completion
  task automatic run_seq(input logic [31:0] w, input logic [31:0] base,
                         input logic [31:0] ia, input bit stall, input bit meddle,
                         input string tag);
    int n = 0, k = 0, cyc = 0, regs[16];
    bit up = w[23], pre = w[24], ld = w[20], wb = w[21], meddled = 0;
    logic [31:0] ea, ewb;
    for (int i = 0; i < 16; i++) if (w[i]) begin regs[n] = i; n++; end
    if (up) ea = pre ? base + 4 : base;
    else    ea = pre ? base - 32'(4*n) : base - 32'(4*(n-1));
    ewb = up ? base + 32'(4*n) : base - 32'(4*n);
    @(negedge clk);
    insn_i = w; base_i = base; iaddr_i = ia; start_i = 1'b1; ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (k < n && cyc < 200) begin
      bit ok;
      ok = beat_valid_o && beat_reg_o == 4'(regs[k]) && beat_addr_o == ea &&
           beat_load_o == ld && beat_pcsub_o == (regs[k] == 15 && !ld) &&
           beat_pcval_o == ia + 32'd12 && !done_o;
      chk(ok, {tag, " beat R1 R2 R3 R4 R6 R7 R12"}, {beat_reg_o, beat_addr_o[27:0]},
          {4'(regs[k]), ea[27:0]});
      if (meddle && !meddled) begin
        meddled = 1;
        ready_i = 1'b0; start_i = 1'b1;
        insn_i = mk(1, 0, 1, 1, 0, 16'h0003);
        @(negedge clk);
        start_i = 1'b0; insn_i = w;
        chk(!err_o && !done_o, {tag, " R11 no pulse on busy start"},
            {30'd0, err_o, done_o}, 32'd0);
        cyc++;
        continue;
      end
      ready_i = !(stall && (cyc % 2 == 0));
      @(negedge clk);
      if (ready_i) begin k++; ea = ea + 4; end
      cyc++;
    end
    ready_i = 1'b1;
    chk(done_o && !beat_valid_o && wb_en_o == wb && (!wb || wb_val_o == ewb),
        {tag, " done R5 R12"}, wb_val_o, ewb);
    @(negedge clk);
    chk(!done_o && !wb_en_o, {tag, " done pulse ends R12"}, {30'd0, done_o, wb_en_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!beat_valid_o && !done_o && !err_o && !wb_en_o, "reset state R12",
        {28'd0, beat_valid_o, done_o, err_o, wb_en_o}, 32'd0);
  endtask

  task automatic t_empty;
    @(negedge clk);
    insn_i = mk(1, 1, 0, 1, 1, 16'h0000); base_i = 32'h0000_7000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !beat_valid_o && wb_en_o && wb_val_o == 32'h0000_7000,
        "empty list R10", wb_val_o, 32'h0000_7000);
    @(negedge clk);
    chk(!done_o && !beat_valid_o, "empty list ends R10", {30'd0, done_o, beat_valid_o}, 32'd0);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    insn_i = mk(0, 1, 1, 1, 0, 16'h00FF); base_i = 32'h100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o && !beat_valid_o && !done_o && !wb_en_o, "illegal pulse R8",
        {28'd0, err_o, beat_valid_o, done_o, wb_en_o}, 32'h8);
    @(negedge clk);
    chk(!err_o && !beat_valid_o && !done_o, "illegal one cycle R8",
        {29'd0, err_o, beat_valid_o, done_o}, 32'd0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // up, after, store, r0 r2 r15, writeback: R2 R6
    run_seq(mk(0, 1, 0, 1, 0, 16'h8005), 32'h0000_1000, 32'h0000_0200, 0, 0, "inc-after");
    // up, before, load, stalls: R2 R9 R7
    run_seq(mk(1, 1, 0, 0, 1, 16'h00F0), 32'h0000_2000, 32'h0000_0300, 1, 0, "inc-before");
    // down, before, store, writeback: R3 R5
    run_seq(mk(1, 0, 0, 1, 0, 16'h0A0A), 32'h0000_3000, 32'h0000_0400, 0, 0, "dec-before");
    // down, after, single load: R3 with n=1
    run_seq(mk(0, 0, 0, 1, 1, 16'h0400), 32'h0000_4000, 32'h0000_0500, 0, 0, "dec-after-1");
    // full list, down, after, store, stalls: R1 R6
    run_seq(mk(0, 0, 0, 1, 0, 16'hFFFF), 32'h0000_5000, 32'h0000_0600, 1, 0, "dec-after-full");
    t_empty();
    t_illegal();
    // busy start: R11
    run_seq(mk(0, 1, 0, 1, 1, 16'h0110), 32'h0000_6000, 32'h0000_0700, 0, 1, "busy-start");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule